// File: doc/BRIEF.md
# Prioritized Interrupt Pending Controller

This block holds a 64-bit pending vector for each of seven interrupt classes and decides, every cycle, whether the core should take an interrupt and which one. Producers post a request by naming a class and a bit within it. Consumers retire a request the same way. A single strobe wipes all pending state at once. Any class's vector can be read back through a read port.

Two mode inputs shape the decision: a hyperprivileged-mode flag and a global interrupt-enable flag. Their effect differs by mode. In hyperprivileged mode only two sources can win, and only while interrupts are enabled. Outside that mode, three high-priority sources win regardless of the enable flag, and the remaining four win only while it is set.

The outputs are a take flag, a 3-bit cause code and a 4-bit level. The level is produced when the winner is a software interrupt. The decision is combinational from the registered state and the current mode inputs.

Top module: `irq_pend_ctrl`

## Requirements
- R1: A post with class code c (0 trap-level-zero, 1 timer match, 2 interrupt vector, 3 CPU mondo, 4 device mondo, 5 resumable error, 6 software) and bit index i sets bit i of vector c at the next rising edge. The read port returns vector `rd_cls_i`, and returns zero for code 7.
- R2: A clear with class c and bit i resets that bit at the next edge. A post or clear naming class code 7 changes no state.
- R3: `summary_o[c]` goes high on any post to class c. It goes low only when a clear leaves vector c all zeros, and it stays high while any bit of c remains set.
- R4: A post and a clear to the same class and bit in one cycle leave the bit set. The summary bit follows the updated vector. A clear-all in the same cycle as a post wins, and everything ends at zero.
- R5: Reset (`rst_ni` low) and the clear-all strobe both zero every vector and every summary bit.
- R6: While every summary bit is zero, `take_o` is low whatever `hpriv_i` and `ie_i` are.
- R7: With `hpriv_i` high, only class 1 and then class 2 can be taken, and only while `ie_i` is high. Every other class is masked.
- R8: With `hpriv_i` low, classes 0, 1 and 2 are taken in that priority order whatever `ie_i` is.
- R9: With `hpriv_i` low and `ie_i` high, and none of classes 0 to 2 pending, the order is class 3, then 4, then 6, then 5.
- R10: `cause_o` equals the winning class code while `take_o` is high, and is 0 otherwise.
- R11: When software interrupts win and bit 0 or bit 16 of vector 6 is set, `level_o` is 14.
- R12: Otherwise `level_o` is the highest set bit of vector 6 among bits 15 down to 1, or 0 if none of them is set. `level_o` is 0 whenever the winner is not class 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_vld_i | input | 1 | Post request strobe |
| set_cls_i | input | 3 | Class code of the post |
| set_idx_i | input | 6 | Bit index of the post |
| clr_vld_i | input | 1 | Clear request strobe |
| clr_cls_i | input | 3 | Class code of the clear |
| clr_idx_i | input | 6 | Bit index of the clear |
| clr_all_i | input | 1 | Zero all vectors and summary bits |
| rd_cls_i | input | 3 | Class code for the read port |
| rd_vec_o | output | 64 | Pending vector of the selected class |
| summary_o | output | 7 | Per-class non-empty flags |
| hpriv_i | input | 1 | Hyperprivileged mode flag |
| ie_i | input | 1 | Global interrupt enable |
| take_o | output | 1 | An interrupt is to be taken |
| cause_o | output | 3 | Winning class code |
| level_o | output | 4 | Software interrupt level |

## Verification
The bound checker assumes that strobes and class codes are stable at the clock edge. It also assumes that class code 7 is the only out-of-range code that can appear on the request ports. The consistency property between the read port and the summary bits relies on `rd_cls_i` naming a real class. The bench drives every input 2 ns after a rising edge and sweeps all three class-code fields over the full 0 to 7 range, so the invalid code is exercised without breaking these assumptions. Bit indices in the random phase come from a small set that includes 0, 15, 16 and 63. This makes same-bit collisions between posts and clears, and the level special cases, occur often.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  localparam int unsigned NUM_CLS = 7;
  localparam int unsigned CLS_W   = $clog2(NUM_CLS + 1);
  localparam int unsigned VEC_W   = 64;
  localparam int unsigned IDX_W   = $clog2(VEC_W);
  localparam int unsigned LVL_W   = 4;
  localparam int unsigned LVL_SCAN = (1 << LVL_W) - 1;

  typedef enum logic [CLS_W-1:0] {
    CLS_TLZ   = 3'd0,
    CLS_TMR   = 3'd1,
    CLS_VEC   = 3'd2,
    CLS_CPUM  = 3'd3,
    CLS_DEVM  = 3'd4,
    CLS_RERR  = 3'd5,
    CLS_SOFT  = 3'd6,
    CLS_NONE  = 3'd7
  } cls_e;

  localparam logic [LVL_W-1:0] LVL_FORCED = 4'd14;
  localparam int unsigned      FORCE_HI_BIT = 16;
endpackage

// File: rtl/irq_pend_store.sv
module irq_pend_store
  import irq_pend_pkg::*;
#(
  parameter int unsigned N_CLS = NUM_CLS,
  parameter int unsigned V_W   = VEC_W,
  localparam int unsigned C_W  = CLS_W,
  localparam int unsigned I_W  = $clog2(V_W)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       set_vld_i,
  input  logic [C_W-1:0]             set_cls_i,
  input  logic [I_W-1:0]             set_idx_i,
  input  logic                       clr_vld_i,
  input  logic [C_W-1:0]             clr_cls_i,
  input  logic [I_W-1:0]             clr_idx_i,
  input  logic                       clr_all_i,
  output logic [N_CLS-1:0][V_W-1:0]  vec_o,
  output logic [N_CLS-1:0]           sum_o
);
  logic [V_W-1:0] set_onehot, clr_onehot;

  always_comb begin
    set_onehot = '0;
    clr_onehot = '0;
    set_onehot[set_idx_i] = 1'b1;
    clr_onehot[clr_idx_i] = 1'b1;
  end

  for (genvar c = 0; c < N_CLS; c++) begin : g_cls
    logic           set_hit, clr_hit;
    logic [V_W-1:0] vec_q, vec_d;
    logic           sum_q, sum_d;

    assign set_hit = set_vld_i && (set_cls_i == C_W'(c));
    assign clr_hit = clr_vld_i && (clr_cls_i == C_W'(c));

    // clear first, then post: a same-bit post survives
    always_comb begin
      vec_d = vec_q;
      if (clr_hit) vec_d = vec_d & ~clr_onehot;
      if (set_hit) vec_d = vec_d | set_onehot;
      sum_d = (set_hit || clr_hit) ? (|vec_d) : sum_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vec_q <= '0;
        sum_q <= 1'b0;
      end else if (clr_all_i) begin
        vec_q <= '0;
        sum_q <= 1'b0;
      end else begin
        vec_q <= vec_d;
        sum_q <= sum_d;
      end
    end

    assign vec_o[c] = vec_q;
    assign sum_o[c] = sum_q;
  end
endmodule

// File: rtl/irq_soft_level.sv
module irq_soft_level
  import irq_pend_pkg::*;
#(
  parameter int unsigned V_W  = VEC_W,
  parameter int unsigned L_W  = LVL_W,
  localparam int unsigned SCAN = (1 << L_W) - 1
) (
  input  logic [V_W-1:0] soft_vec_i,
  output logic [L_W-1:0] level_o
);
  logic [L_W-1:0] scan_lvl;
  logic           force_lvl;

  always_comb begin
    scan_lvl = '0;
    for (int unsigned b = 1; b <= SCAN; b++) begin
      if (soft_vec_i[b]) scan_lvl = L_W'(b);
    end
  end

  assign force_lvl = soft_vec_i[0] | soft_vec_i[FORCE_HI_BIT];
  assign level_o   = force_lvl ? LVL_FORCED : scan_lvl;
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_pend_pkg::*;
#(
  parameter int unsigned N_CLS = NUM_CLS,
  localparam int unsigned C_W  = CLS_W
) (
  input  logic [N_CLS-1:0] sum_i,
  input  logic             hpriv_i,
  input  logic             ie_i,
  output logic             take_o,
  output logic [C_W-1:0]   cause_o
);
  logic [N_CLS-1:0] elig;

  // mode mask
  always_comb begin
    elig = '0;
    if (hpriv_i) begin
      if (ie_i) begin
        elig[CLS_TMR] = sum_i[CLS_TMR];
        elig[CLS_VEC] = sum_i[CLS_VEC];
      end
    end else begin
      elig[CLS_TLZ] = sum_i[CLS_TLZ];
      elig[CLS_TMR] = sum_i[CLS_TMR];
      elig[CLS_VEC] = sum_i[CLS_VEC];
      if (ie_i) begin
        elig[CLS_CPUM] = sum_i[CLS_CPUM];
        elig[CLS_DEVM] = sum_i[CLS_DEVM];
        elig[CLS_SOFT] = sum_i[CLS_SOFT];
        elig[CLS_RERR] = sum_i[CLS_RERR];
      end
    end
  end

  // fixed order; software sits ahead of resumable error
  always_comb begin
    take_o  = 1'b1;
    cause_o = '0;
    if      (elig[CLS_TLZ])  cause_o = CLS_TLZ;
    else if (elig[CLS_TMR])  cause_o = CLS_TMR;
    else if (elig[CLS_VEC])  cause_o = CLS_VEC;
    else if (elig[CLS_CPUM]) cause_o = CLS_CPUM;
    else if (elig[CLS_DEVM]) cause_o = CLS_DEVM;
    else if (elig[CLS_SOFT]) cause_o = CLS_SOFT;
    else if (elig[CLS_RERR]) cause_o = CLS_RERR;
    else                     take_o  = 1'b0;
  end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pend_pkg::*;
#(
  parameter int unsigned N_CLS = NUM_CLS,
  parameter int unsigned V_W   = VEC_W,
  parameter int unsigned L_W   = LVL_W,
  localparam int unsigned C_W  = CLS_W,
  localparam int unsigned I_W  = $clog2(V_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_vld_i,
  input  logic [C_W-1:0]   set_cls_i,
  input  logic [I_W-1:0]   set_idx_i,
  input  logic             clr_vld_i,
  input  logic [C_W-1:0]   clr_cls_i,
  input  logic [I_W-1:0]   clr_idx_i,
  input  logic             clr_all_i,
  input  logic [C_W-1:0]   rd_cls_i,
  output logic [V_W-1:0]   rd_vec_o,
  output logic [N_CLS-1:0] summary_o,
  input  logic             hpriv_i,
  input  logic             ie_i,
  output logic             take_o,
  output logic [C_W-1:0]   cause_o,
  output logic [L_W-1:0]   level_o
);
  logic [N_CLS-1:0][V_W-1:0] vec;
  logic [N_CLS-1:0]          sum;
  logic [L_W-1:0]            soft_lvl;

  irq_pend_store #(.N_CLS(N_CLS), .V_W(V_W)) u_store (
    .clk_i, .rst_ni,
    .set_vld_i, .set_cls_i, .set_idx_i,
    .clr_vld_i, .clr_cls_i, .clr_idx_i,
    .clr_all_i,
    .vec_o (vec),
    .sum_o (sum)
  );

  irq_prio_sel #(.N_CLS(N_CLS)) u_sel (
    .sum_i   (sum),
    .hpriv_i,
    .ie_i,
    .take_o,
    .cause_o
  );

  irq_soft_level #(.V_W(V_W), .L_W(L_W)) u_lvl (
    .soft_vec_i (vec[CLS_SOFT]),
    .level_o    (soft_lvl)
  );

  always_comb begin
    rd_vec_o = '0;
    for (int unsigned c = 0; c < N_CLS; c++) begin
      if (rd_cls_i == C_W'(c)) rd_vec_o = vec[c];
    end
  end

  assign summary_o = sum;
  assign level_o   = (take_o && cause_o == CLS_SOFT) ? soft_lvl : '0;
endmodule

// File: rtl/irq_pend_ctrl_chk.sv
module irq_pend_ctrl_chk
  import irq_pend_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 set_vld_i,
  input logic [CLS_W-1:0]     set_cls_i,
  input logic [IDX_W-1:0]     set_idx_i,
  input logic                 clr_vld_i,
  input logic [CLS_W-1:0]     clr_cls_i,
  input logic [IDX_W-1:0]     clr_idx_i,
  input logic                 clr_all_i,
  input logic [CLS_W-1:0]     rd_cls_i,
  input logic [VEC_W-1:0]     rd_vec_o,
  input logic [NUM_CLS-1:0]   summary_o,
  input logic                 hpriv_i,
  input logic                 ie_i,
  input logic                 take_o,
  input logic [CLS_W-1:0]     cause_o,
  input logic [LVL_W-1:0]     level_o
);
  assert_post_sets_sum_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_vld_i && set_cls_i < CLS_W'(NUM_CLS) && !clr_all_i)
      |=> (((summary_o >> $past(set_cls_i)) & 7'd1) != 7'd0));

  assert_clr_all_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_all_i |=> (summary_o == '0 && rd_vec_o == '0));

  assert_idle_no_take_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (summary_o == '0) |-> !take_o);

  assert_hpriv_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hpriv_i && take_o) |-> (ie_i && (cause_o == CLS_TMR || cause_o == CLS_VEC)));

  assert_high_ignore_ie_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hpriv_i && summary_o[CLS_TLZ]) |-> (take_o && cause_o == CLS_TLZ));

  assert_cause_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> (cause_o == '0));

  assert_cause_pending_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (((summary_o >> cause_o) & 7'd1) != 7'd0));

  assert_level_qual_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(take_o && cause_o == CLS_SOFT) |-> (level_o == '0));

  assert_read_sum_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cls_i < CLS_W'(NUM_CLS)) |-> ((((summary_o >> rd_cls_i) & 7'd1) != 7'd0) == (rd_vec_o != '0)));

  assert_bad_read_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cls_i == CLS_NONE) |-> (rd_vec_o == '0));
endmodule

bind irq_pend_ctrl irq_pend_ctrl_chk u_chk (.*);

// File: tb/irq_pend_ctrl_tb.sv
module irq_pend_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        set_vld_i = 0, clr_vld_i = 0, clr_all_i = 0;
  logic [2:0]  set_cls_i = 0, clr_cls_i = 0, rd_cls_i = 0;
  logic [5:0]  set_idx_i = 0, clr_idx_i = 0;
  logic        hpriv_i = 0, ie_i = 0;
  logic [63:0] rd_vec_o;
  logic [6:0]  summary_o;
  logic        take_o;
  logic [2:0]  cause_o;
  logic [3:0]  level_o;

  int checks = 0, errors = 0;
  string cur_req = "R5";

  logic [63:0] m_vec [8];
  logic [6:0]  m_sum;

  always #4 clk_i = ~clk_i;

  irq_pend_ctrl u_dut (.*);

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic mdl_reset();
    for (int c = 0; c < 8; c++) m_vec[c] = '0;
    m_sum = '0;
  endtask

  task automatic mdl_update();
    if (clr_all_i) begin
      mdl_reset();
    end else begin
      if (clr_vld_i && clr_cls_i != 3'd7) m_vec[clr_cls_i][clr_idx_i] = 1'b0;
      if (set_vld_i && set_cls_i != 3'd7) m_vec[set_cls_i][set_idx_i] = 1'b1;
      if (clr_vld_i && clr_cls_i != 3'd7) m_sum[clr_cls_i] = (m_vec[clr_cls_i] != 0);
      if (set_vld_i && set_cls_i != 3'd7) m_sum[set_cls_i] = 1'b1;
    end
  endtask

  function automatic int exp_cause();
    int order_hp[2] = '{1, 2};
    int order_lo[7] = '{0, 1, 2, 3, 4, 6, 5};
    if (hpriv_i) begin
      if (!ie_i) return -1;
      foreach (order_hp[k]) if (m_sum[order_hp[k]]) return order_hp[k];
      return -1;
    end
    foreach (order_lo[k]) begin
      if (k >= 3 && !ie_i) return -1;
      if (m_sum[order_lo[k]]) return order_lo[k];
    end
    return -1;
  endfunction

  function automatic int exp_level();
    logic [63:0] s = m_vec[6];
    if (s[0] || s[16]) return 14;
    for (int b = 15; b >= 1; b--) if (s[b]) return b;
    return 0;
  endfunction

  task automatic compare();
    int c = exp_cause();
    chk("take", 64'(take_o), 64'(c >= 0));
    chk("cause R10", 64'(cause_o), (c >= 0) ? 64'(c) : 64'd0);
    chk("level R11/R12", 64'(level_o), (c == 6) ? 64'(exp_level()) : 64'd0);
    chk("rd_vec R1", rd_vec_o, (rd_cls_i == 3'd7) ? 64'd0 : m_vec[rd_cls_i]);
    chk("summary R3", 64'(summary_o), 64'(m_sum));
  endtask

  task automatic tick();
    @(posedge clk_i);
    if (rst_ni) mdl_update();
    #2;
    compare();
    set_vld_i = 0; clr_vld_i = 0; clr_all_i = 0;
  endtask

  task automatic post(int c, int i);
    set_vld_i = 1; set_cls_i = 3'(c); set_idx_i = 6'(i);
  endtask

  task automatic clr(int c, int i);
    clr_vld_i = 1; clr_cls_i = 3'(c); clr_idx_i = 6'(i);
  endtask

  task automatic modes(bit hp, bit ie);
    hpriv_i = hp; ie_i = ie;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int idx_set[6] = '{0, 1, 5, 15, 16, 63};
    mdl_reset();
    // R5 reset state
    cur_req = "R5";
    repeat (3) tick();
    #1 rst_ni = 1'b1;
    tick();

    // R1 post and read back, R11 forced level via bit 0
    cur_req = "R11";
    modes(0, 1); rd_cls_i = 3'd6;
    post(6, 0); tick();
    chk("level R11 bit0", 64'(level_o), 64'd14);
    clr(6, 0); post(6, 16); tick();
    chk("level R11 bit16", 64'(level_o), 64'd14);

    // R12 highest bit
    cur_req = "R12";
    post(6, 5); tick();
    clr(6, 16); tick();
    chk("level R12 bit5", 64'(level_o), 64'd5);
    post(6, 15); tick();
    chk("level R12 bit15", 64'(level_o), 64'd15);
    clr(6, 15); tick();
    clr(6, 5); post(6, 40); tick();
    chk("level R12 none", 64'(level_o), 64'd0);
    chk("take R12 high bit only", 64'(take_o), 64'd1);

    // R3 summary held until last bit cleared
    cur_req = "R3";
    post(6, 41); tick();
    clr(6, 40); tick();
    chk("sum R3 still set", 64'(summary_o[6]), 64'd1);
    clr(6, 41); tick();
    chk("sum R3 cleared", 64'(summary_o[6]), 64'd0);
    clr(6, 41); tick();

    // R4 post and clear same bit
    cur_req = "R4";
    rd_cls_i = 3'd3;
    post(3, 9); clr(3, 9); tick();
    chk("R4 bit survives", rd_vec_o, 64'h200);
    clr_all_i = 1; post(4, 2); tick();
    chk("R4 clear-all wins", 64'(summary_o), 64'd0);

    // R2 class code 7 ignored
    cur_req = "R2";
    rd_cls_i = 3'd7;
    post(7, 3); tick();
    chk("R2 no state", 64'(summary_o), 64'd0);
    post(2, 7); tick();
    clr(7, 7); rd_cls_i = 3'd2; tick();
    chk("R2 clear code7", rd_vec_o, 64'h80);
    clr(2, 7); tick();

    // R6 nothing pending across all modes
    cur_req = "R6";
    for (int m = 0; m < 4; m++) begin modes(m[1], m[0]); tick(); end

    // R7 R8 R9 priority walk: fill all classes, remove winners one by one
    for (int c = 0; c < 7; c++) begin post(c, c + 3); tick(); end
    cur_req = "R7";
    modes(1, 1); tick(); chk("R7 timer first", 64'(cause_o), 64'd1);
    modes(1, 0); tick(); chk("R7 ie off", 64'(take_o), 64'd0);
    cur_req = "R8";
    modes(0, 0); tick(); chk("R8 tlz ie off", 64'(cause_o), 64'd0);
    clr(0, 3); tick(); chk("R8 timer", 64'(cause_o), 64'd1);
    clr(1, 4); tick(); chk("R8 vector", 64'(cause_o), 64'd2);
    modes(1, 1); tick(); chk("R7 vector", 64'(cause_o), 64'd2);
    clr(2, 5); tick(); chk("R7 masked rest", 64'(take_o), 64'd0);
    cur_req = "R9";
    modes(0, 0); tick(); chk("R9 ie off", 64'(take_o), 64'd0);
    modes(0, 1); tick(); chk("R9 cpu", 64'(cause_o), 64'd3);
    clr(3, 6); tick(); chk("R9 dev", 64'(cause_o), 64'd4);
    clr(4, 7); tick(); chk("R9 soft before rerr", 64'(cause_o), 64'd6);
    clr(6, 9); tick(); chk("R9 rerr", 64'(cause_o), 64'd5);
    clr_all_i = 1; tick();

    // R1 R10 random traffic against the model
    cur_req = "R1/R10";
    for (int n = 0; n < 4000; n++) begin
      set_vld_i = 1'($urandom_range(0, 1));
      set_cls_i = 3'($urandom_range(0, 7));
      set_idx_i = 6'(idx_set[$urandom_range(0, 5)]);
      clr_vld_i = 1'($urandom_range(0, 1));
      clr_cls_i = 3'($urandom_range(0, 7));
      clr_idx_i = 6'(idx_set[$urandom_range(0, 5)]);
      clr_all_i = ($urandom_range(0, 99) == 0);
      rd_cls_i  = 3'($urandom_range(0, 7));
      modes(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      tick();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule